// File: doc/BRIEF.md
# Interrupt Holdoff and Gating Controller

This block drives the host interrupt line from a single pending-and-unmasked summary produced by the interrupt status logic. Two conditions gate the line. The first is a software enable bit: clearing it silences the line at once, and the status and mask registers stay as they are. The second is a holdoff timer that keeps the line quiet for a programmed number of 100 µs periods after each read of the status register. This lets software drain a burst of events before it is interrupted again.

Software reaches two 32-bit registers through a plain register port. Register select 0 holds the enable. Register select 1 holds the holdoff count and a start-mode bit. A status-read strobe from the status logic reloads the timer. An internal prescaler divides the system clock into 100 µs ticks. The tick period in clocks is the parameter `TICK_DIV`. There is no streaming data path, so every pin is a plain level or strobe and there is no valid/ready handshake.

Top module: `irq_holdoff_gate`

## Requirements
- R1: When bit 0 of register select 0 (the enable) is 0, `irq_out` is 0 in the following cycle, whatever the pending input or the timer state.
- R2: A read of register select 0 returns the enable in bit 0. A read of register select 1 returns the holdoff count in bits 7-0 and the start-mode bit in bit 8. Every other bit reads 0, even when a write set it to 1.
- R3: A `status_rd` pulse with a nonzero holdoff count loads the timer. From the second clock after the pulse, `irq_out` stays 0 until the timer expires.
- R4: With start mode 0, the countdown starts in the first cycle after the load in which the enable is 1. Once it has started it keeps running. The timer expires after count × `TICK_DIV` clocks of running, and the count never increases while running.
- R5: With start mode 1, the loaded timer waits until the enable and the pending input are both 1. Only then does the countdown start.
- R6: `irq_out` is a registered copy of enable AND pending AND timer-expired, taken one clock earlier.
- R7: A holdoff count of 0 means the timer is expired again on the clock after `status_rd`, so there is no suppression.
- R8: A `status_rd` pulse during a countdown reloads the count and re-arms the start condition. It also restarts the prescaler, so the full holdoff interval is measured again from that read.
- R9: `rst_n` low or `soft_rst` high clears both registers and `irq_out`, and leaves the timer expired.
- R10: The start mode used by a countdown is the value of the start-mode bit at the `status_rd` pulse. Later writes to that bit do not affect the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hard reset, active low, synchronous |
| soft_rst | input | 1 | Soft reset, active high, synchronous |
| reg_sel | input | 1 | Register select: 0 enable, 1 holdoff |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| status_rd | input | 1 | One-cycle strobe: the status register was read |
| pend_in | input | 1 | Some interrupt is pending and unmasked |
| irq_out | output | 1 | Host interrupt, registered |

## Verification
A wrong timer state appears at `irq_out` in one of two ways. If the timer is stuck, the line stays low for good. If the timer expires early, the line rises too soon, and this becomes visible one clock after the pending input is high. Start-mode faults, such as counting before the pending input arrives or taking the live bit instead of the latched one, shift the rising edge by whole prescaler periods. A per-cycle reference model therefore catches them on the first cycle of difference. Register faults show on `reg_rdata` at once, in the cycle after the write.

// File: rtl/irq_holdoff_pkg.sv
package irq_holdoff_pkg;
  typedef enum logic [1:0] {
    HO_IDLE  = 2'd0,
    HO_ARMED = 2'd1,
    HO_RUN   = 2'd2
  } ho_state_e;

  localparam int REG_W   = 32;
  localparam int CTL_BIT = 8;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_holdoff_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              en,
  output logic [HOLD_W-1:0] hold,
  output logic              ctl
);
  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      en   <= 1'b0;
      hold <= '0;
      ctl  <= 1'b0;
    end else if (reg_wr) begin
      if (!reg_sel) begin
        en <= reg_wdata[0];
      end else begin
        hold <= reg_wdata[HOLD_W-1:0];
        ctl  <= reg_wdata[CTL_BIT];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_sel) begin
      reg_rdata[0] = en;
    end else begin
      reg_rdata[HOLD_W-1:0] = hold;
      reg_rdata[CTL_BIT]    = ctl;
    end
  end
endmodule

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int TICK_DIV = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_q;

  assign tick = run && !clear && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst || clear) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/irq_holdoff_timer.sv
module irq_holdoff_timer
  import irq_holdoff_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              load,
  input  logic [HOLD_W-1:0] hold,
  input  logic              ctl,
  input  logic              en,
  input  logic              pend,
  input  logic              tick,
  output ho_state_e         state,
  output logic [HOLD_W-1:0] cnt,
  output logic              ctl_l,
  output logic              restart,
  output logic              expired
);
  logic start;

  assign start   = (state == HO_ARMED) && !load && (ctl_l ? (en && pend) : en);
  assign restart = load || start;
  assign expired = (state == HO_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      state <= HO_IDLE;
      cnt   <= '0;
      ctl_l <= 1'b0;
    end else if (load) begin
      cnt   <= hold;
      ctl_l <= ctl;
      state <= (hold == '0) ? HO_IDLE : HO_ARMED;
    end else begin
      unique case (state)
        HO_ARMED: if (start) state <= HO_RUN;
        HO_RUN: if (tick) begin
          if (cnt == HOLD_W'(1)) begin
            state <= HO_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= HO_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_holdoff_gate.sv
module irq_holdoff_gate
  import irq_holdoff_pkg::*;
#(
  parameter int TICK_DIV = 10000,
  parameter int HOLD_W   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        status_rd,
  input  logic        pend_in,
  output logic        irq_out
);
  logic              en_q;
  logic [HOLD_W-1:0] hold_q;
  logic              ctl_q;
  logic              ctl_l;
  logic              tick;
  logic              restart;
  logic              expired;
  ho_state_e         tm_state;
  logic [HOLD_W-1:0] tm_cnt;
  logic              irq_q;

  irq_cfg_regs #(.HOLD_W(HOLD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .en(en_q), .hold(hold_q), .ctl(ctl_q)
  );

  irq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .clear(restart), .run(tm_state == HO_RUN), .tick(tick)
  );

  irq_holdoff_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .load(status_rd), .hold(hold_q), .ctl(ctl_q), .en(en_q),
    .pend(pend_in), .tick(tick), .state(tm_state), .cnt(tm_cnt),
    .ctl_l(ctl_l), .restart(restart), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) irq_q <= 1'b0;
    else                    irq_q <= en_q && pend_in && expired;
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/irq_holdoff_gate_chk.sv
module irq_holdoff_gate_chk
  import irq_holdoff_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              en,
  input logic [HOLD_W-1:0] hold,
  input logic              ctl_l,
  input logic              pend,
  input logic              status_rd,
  input logic              irq_out,
  input ho_state_e         state,
  input logic [HOLD_W-1:0] cnt
);
  AST_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    !en |=> !irq_out); // R1
  AST_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (status_rd && hold != '0) |=> (state != HO_IDLE)); // R3
  AST_QUIET_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (state != HO_IDLE) |=> !irq_out); // R3
  AST_COUNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (state == HO_RUN && !status_rd) |=> (cnt <= $past(cnt))); // R4
  AST_WAIT_FOR_EVENT: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (state == HO_ARMED && ctl_l && !(en && pend) && !status_rd) |=> (state == HO_ARMED)); // R5
  AST_ZERO_FREE: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (status_rd && hold == '0) |=> (state == HO_IDLE)); // R7
endmodule

bind irq_holdoff_gate irq_holdoff_gate_chk #(.HOLD_W(HOLD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .en(en_q), .hold(hold_q),
  .ctl_l(ctl_l), .pend(pend_in), .status_rd(status_rd), .irq_out(irq_out),
  .state(tm_state), .cnt(tm_cnt)
);

// File: tb/irq_holdoff_gate_test.sv
module irq_holdoff_gate_test;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        status_rd = 1'b0;
  logic        pend_in = 1'b0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  always #5 clk = ~clk;

  irq_holdoff_gate #(.TICK_DIV(DIV), .HOLD_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .status_rd(status_rd), .pend_in(pend_in), .irq_out(irq_out)
  );

  // behavioural reference: phase 0 free, 1 waiting to start, 2 counting
  bit m_en, m_ctl, m_ctl_l, m_irq;
  int m_hold, m_phase, m_left, m_clk;

  always @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      m_en = 0; m_ctl = 0; m_ctl_l = 0; m_irq = 0;
      m_hold = 0; m_phase = 0; m_left = 0; m_clk = 0;
    end else begin
      m_irq = m_en && pend_in && (m_phase == 0);
      if (status_rd) begin
        m_left = m_hold; m_ctl_l = m_ctl; m_clk = 0;
        m_phase = (m_hold == 0) ? 0 : 1;
      end else if (m_phase == 1) begin
        if (m_ctl_l ? (m_en && pend_in) : m_en) begin
          m_phase = 2; m_clk = 0;
        end
      end else if (m_phase == 2) begin
        m_clk++;
        if (m_clk == DIV) begin
          m_clk = 0; m_left--;
          if (m_left == 0) m_phase = 0;
        end
      end
      if (reg_wr) begin
        if (!reg_sel) m_en = reg_wdata[0];
        else begin m_hold = reg_wdata[7:0]; m_ctl = reg_wdata[8]; end
      end
    end
  end

  function automatic logic [31:0] m_rdata();
    return reg_sel ? {23'd0, m_ctl, m_hold[7:0]} : {31'd0, m_en};
  endfunction

  always @(negedge clk) begin
    if (rst_n && !soft_rst) begin
      checks++;
      if (irq_out !== m_irq) begin
        errors++;
        $display("FAIL R6 model irq_out actual %0b expected %0b at %0t", irq_out, m_irq, $time);
      end
      checks++;
      if (reg_rdata !== m_rdata()) begin
        errors++;
        $display("FAIL R2 model reg_rdata actual %h expected %h at %0t", reg_rdata, m_rdata(), $time);
      end
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1; step(1); reg_wr = 1'b0;
  endtask

  task automatic rd_status();
    status_rd = 1'b1; step(1); status_rd = 1'b0;
  endtask

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    @(negedge clk);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
    @(posedge clk); #1;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL R6 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3); rst_n = 1'b1; step(1);
    reg_sel = 0; chk(reg_rdata, 0, "R9 enable after reset");
    chk({31'd0, irq_out}, 0, "R9 irq after reset");
    // R2 readback with junk bits
    wr(0, 32'hFFFF_FFFE); chk(reg_rdata, 0, "R2 enable bit0 clear");
    wr(0, 32'h0000_0001); chk(reg_rdata, 1, "R2 enable bit0 set");
    wr(1, 32'hFFFF_F003); reg_sel = 1; chk(reg_rdata, 32'h3, "R2 holdoff readback");
    pend_in = 1; step(2);
    chk({31'd0, irq_out}, 1, "R6 pend with enable");
    // R3 / R4 start mode 0
    rd_status(); step(1);
    chk({31'd0, irq_out}, 0, "R3 suppressed after read");
    step(8); chk({31'd0, irq_out}, 0, "R4 still counting");
    step(10); chk({31'd0, irq_out}, 1, "R4 expired");
    // R1 gating
    wr(0, 0); step(1); chk({31'd0, irq_out}, 0, "R1 enable off masks");
    // mode 0, count waits for enable
    rd_status(); step(30); chk({31'd0, irq_out}, 0, "R1 still masked");
    wr(0, 1); step(3); chk({31'd0, irq_out}, 0, "R4 count starts on enable");
    step(20); chk({31'd0, irq_out}, 1, "R4 expired after enable");
    // R5 start mode 1
    wr(1, 32'h102); pend_in = 0; rd_status(); step(40);
    pend_in = 1; step(3); chk({31'd0, irq_out}, 0, "R5 count waits for pending");
    step(16); chk({31'd0, irq_out}, 1, "R5 expired");
    // R10 latched start mode
    pend_in = 0; rd_status(); wr(1, 32'h002); step(30);
    pend_in = 1; step(3); chk({31'd0, irq_out}, 0, "R10 latched mode kept");
    step(16); chk({31'd0, irq_out}, 1, "R10 expired");
    // R7 zero holdoff
    wr(1, 0); rd_status(); step(1);
    chk({31'd0, irq_out}, 1, "R7 no suppression");
    // R8 re-read
    wr(1, 32'h005); rd_status(); step(12); rd_status(); step(16);
    chk({31'd0, irq_out}, 0, "R8 reload extends holdoff");
    step(10); chk({31'd0, irq_out}, 1, "R8 expired after reload");
    // R9 soft reset
    soft_rst = 1; step(1); soft_rst = 0;
    reg_sel = 1; chk(reg_rdata, 0, "R9 holdoff cleared");
    reg_sel = 0; chk(reg_rdata, 0, "R9 enable cleared");
    chk({31'd0, irq_out}, 0, "R9 irq cleared");
    step(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule